// File: doc/BRIEF.md
# Serial Peripheral Control Register File

This block is the bus-facing side of a small serial peripheral. It sits on an APB3 bus as a subordinate and offers five registers: a configuration word, a read-only flag word, a baud divisor, a write-only send port and a read-only receive port. The configuration and divisor values drive the serial core continuously. The flag word and the received byte come from that core as inputs and pass straight through to the read path.

Accesses to the two data ports are commands as well as data moves. A completed write to the send port gives the core a one-clock start pulse and the byte to send. A completed read of the receive port gives the core a one-clock pop pulse, so it can release the byte and clear its ready flag. Every transfer finishes in its ACCESS cycle, because the block never inserts wait states.

Byte offsets, which software depends on: configuration 0x00, flags 0x04, divisor 0x08, send 0x0C, receive 0x10. Decode compares the full address, so any other offset is unmapped.

Top module: `serial_csr_apb`

## Requirements
- R1: While `rst` is high at a rising clock edge, configuration and divisor clear to zero and `tx_start`, `rx_pop` and `tx_byte` clear to zero. After reset, reads of offsets 0x00 and 0x08 return zero.
- R2: A write to 0x00 or 0x08 stores `pwdata` at the edge that ends the ACCESS cycle (`psel`, `penable` and `pwrite` all high). Later reads of that offset return the stored value.
- R3: A cycle in which `psel` and `penable` are not both high changes no register and raises no strobe. This includes a SETUP cycle that carries a write.
- R4: A write to an unmapped offset changes no register. A read of an unmapped offset returns all zeros. Offsets that fall between mapped words, such as 0x01, count as unmapped.
- R5: Writes to the read-only offsets 0x04 and 0x10 change no register and raise no strobe.
- R6: A read of the write-only offset 0x0C returns zero.
- R7: A read of 0x04 returns `core_busy` in bit 0, `core_rx_ready` in bit 1 and `core_error` in bit 2. All other bits read as zero.
- R8: A read of 0x10 returns `core_rx_byte` zero-extended to the data width.
- R9: A completed write to 0x0C sets `tx_start` high for exactly the one clock cycle after the ACCESS edge. In that cycle `tx_byte` equals the low byte of the written `pwdata`, and `tx_byte` keeps that value afterwards.
- R10: A completed read of 0x10 sets `rx_pop` high for exactly the one clock cycle after the ACCESS edge. A SETUP cycle alone does not raise it.
- R11: `pready` is high in every cycle.
- R12: `ctrl_out` and `baud_out` always show the current configuration and divisor register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | High in the ACCESS cycle |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, combinational from the offset |
| pready | output | 1 | Transfer complete, always high |
| core_busy | input | 1 | Core transmit-busy flag |
| core_rx_ready | input | 1 | Core has a received byte |
| core_error | input | 1 | Core error flag |
| core_rx_byte | input | BYTE_W | Received byte from the core |
| tx_start | output | 1 | One-cycle send command |
| tx_byte | output | BYTE_W | Byte to send |
| rx_pop | output | 1 | One-cycle receive acknowledge |
| ctrl_out | output | DATA_W | Configuration register value |
| baud_out | output | DATA_W | Divisor register value |

## Verification
A wrong register value shows up on `ctrl_out` or `baud_out` in the cycle after the faulty edge, and on `prdata` at the next read of that offset. A decode fault puts a value into the wrong register, or lets an unmapped, read-only or SETUP-cycle write through, and the read-backs expose it one transfer later. A strobe fault shows up one cycle after the ACCESS edge: the pulse is missing, lasts more than one cycle, appears after a SETUP cycle only, or carries the wrong byte. For this reason the bench checks the strobes in the cycle right after ACCESS and again one cycle later.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

  // Byte offsets of the register words (software decodes these)
  localparam int OFF_CFG   = 'h00;
  localparam int OFF_FLAGS = 'h04;
  localparam int OFF_DIV   = 'h08;
  localparam int OFF_SEND  = 'h0C;
  localparam int OFF_RECV  = 'h10;

  // Flag bit positions inside the flag word
  localparam int FLAG_BUSY = 0;
  localparam int FLAG_RDY  = 1;
  localparam int FLAG_ERR  = 2;
  localparam int N_FLAGS   = 3;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CFG   = 3'd1,
    SEL_FLAGS = 3'd2,
    SEL_DIV   = 3'd3,
    SEL_SEND  = 3'd4,
    SEL_RECV  = 3'd5
  } reg_sel_e;

  // Storage-backed read-write registers, in slot order
  localparam int N_RW = 2;
  localparam int SLOT_CFG = 0;
  localparam int SLOT_DIV = 1;

  function automatic reg_sel_e rw_slot_sel(input int slot);
    return (slot == SLOT_CFG) ? SEL_CFG : SEL_DIV;
  endfunction

endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFF_CFG))        sel = SEL_CFG;
    else if (addr == ADDR_W'(OFF_FLAGS)) sel = SEL_FLAGS;
    else if (addr == ADDR_W'(OFF_DIV))   sel = SEL_DIV;
    else if (addr == ADDR_W'(OFF_SEND))  sel = SEL_SEND;
    else if (addr == ADDR_W'(OFF_RECV))  sel = SEL_RECV;
    else                                 sel = SEL_NONE;
  end

endmodule

// File: rtl/serial_csr_rwbank.sv
module serial_csr_rwbank
  import serial_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_commit,
  input  reg_sel_e                      sel,
  input  logic [DATA_W-1:0]             wdata,
  output logic [N_RW-1:0][DATA_W-1:0]   q
);

  // One storage word per read-write slot; each loads only in ACCESS
  for (genvar s = 0; s < N_RW; s++) begin : g_slot
    localparam reg_sel_e MY_SEL = rw_slot_sel(s);
    always_ff @(posedge clk) begin
      if (rst)
        q[s] <= '0;
      else if (wr_commit && sel == MY_SEL)
        q[s] <= wdata;
    end
  end

endmodule

// File: rtl/serial_csr_rdmux.sv
module serial_csr_rdmux
  import serial_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  reg_sel_e                    sel,
  input  logic [N_RW-1:0][DATA_W-1:0] rw_q,
  input  logic [N_FLAGS-1:0]          flags,
  input  logic [BYTE_W-1:0]           rx_byte,
  output logic [DATA_W-1:0]           rdata
);

  localparam int FLAG_PAD = DATA_W - N_FLAGS;
  localparam int BYTE_PAD = DATA_W - BYTE_W;

  always_comb begin
    case (sel)
      SEL_CFG:   rdata = rw_q[SLOT_CFG];
      SEL_DIV:   rdata = rw_q[SLOT_DIV];
      SEL_FLAGS: rdata = {{FLAG_PAD{1'b0}}, flags};
      SEL_RECV:  rdata = {{BYTE_PAD{1'b0}}, rx_byte};
      default:   rdata = '0;   // send port, unmapped
    endcase
  end

endmodule

// File: rtl/serial_csr_strobe.sv
module serial_csr_strobe
  import serial_csr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_commit,
  input  logic              rd_commit,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tx_start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_pop
);

  logic send_hit;
  logic recv_hit;

  assign send_hit = wr_commit && (sel == SEL_SEND);
  assign recv_hit = rd_commit && (sel == SEL_RECV);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start <= 1'b0;
      rx_pop   <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_start <= send_hit;
      rx_pop   <= recv_hit;
      if (send_hit)
        tx_byte <= wbyte;
    end
  end

endmodule

// File: rtl/serial_csr_apb.sv
module serial_csr_apb
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              core_busy,
  input  logic              core_rx_ready,
  input  logic              core_error,
  input  logic [BYTE_W-1:0] core_rx_byte,
  output logic              tx_start,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rx_pop,
  output logic [DATA_W-1:0] ctrl_out,
  output logic [DATA_W-1:0] baud_out
);

  reg_sel_e                    sel;
  logic                        access;
  logic                        wr_commit;
  logic                        rd_commit;
  logic [N_RW-1:0][DATA_W-1:0] rw_q;
  logic [N_FLAGS-1:0]          flags;

  assign access    = psel && penable;
  assign wr_commit = access && pwrite;
  assign rd_commit = access && !pwrite;

  always_comb begin
    flags            = '0;
    flags[FLAG_BUSY] = core_busy;
    flags[FLAG_RDY]  = core_rx_ready;
    flags[FLAG_ERR]  = core_error;
  end

  serial_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (paddr),
    .sel  (sel)
  );

  serial_csr_rwbank #(.DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_commit (wr_commit),
    .sel       (sel),
    .wdata     (pwdata),
    .q         (rw_q)
  );

  serial_csr_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_mux (
    .sel     (sel),
    .rw_q    (rw_q),
    .flags   (flags),
    .rx_byte (core_rx_byte),
    .rdata   (prdata)
  );

  serial_csr_strobe #(.BYTE_W(BYTE_W)) u_stb (
    .clk       (clk),
    .rst       (rst),
    .wr_commit (wr_commit),
    .rd_commit (rd_commit),
    .sel       (sel),
    .wbyte     (pwdata[BYTE_W-1:0]),
    .tx_start  (tx_start),
    .tx_byte   (tx_byte),
    .rx_pop    (rx_pop)
  );

  assign pready   = 1'b1;
  assign ctrl_out = rw_q[SLOT_CFG];
  assign baud_out = rw_q[SLOT_DIV];

endmodule

// File: rtl/serial_csr_apb_chk.sv
module serial_csr_apb_chk
  import serial_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              tx_start,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              rx_pop,
  input logic [DATA_W-1:0] ctrl_out,
  input logic [DATA_W-1:0] baud_out
);

  logic mapped;
  assign mapped = (paddr == ADDR_W'(OFF_CFG))  || (paddr == ADDR_W'(OFF_FLAGS)) ||
                  (paddr == ADDR_W'(OFF_DIV))  || (paddr == ADDR_W'(OFF_SEND))  ||
                  (paddr == ADDR_W'(OFF_RECV));

  assert_ready_high_R11: assert property (@(posedge clk) disable iff (rst) pready);

  assert_setup_no_change_R3: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable) |=> ($stable(ctrl_out) && $stable(baud_out) && !tx_start && !rx_pop));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (prdata == '0));

  assert_send_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (paddr == ADDR_W'(OFF_SEND)) |-> (prdata == '0));

  assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && paddr == ADDR_W'(OFF_SEND))
      |=> (tx_start && tx_byte == $past(pwdata[BYTE_W-1:0])));

  assert_tx_single_R9: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_rx_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pwrite && paddr == ADDR_W'(OFF_RECV)) |=> rx_pop);

  assert_rx_single_R10: assert property (@(posedge clk) disable iff (rst)
    rx_pop |=> !rx_pop);

  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite && paddr == ADDR_W'(OFF_CFG)) |=> (ctrl_out == $past(pwdata)));

endmodule

bind serial_csr_apb serial_csr_apb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (.*);

// File: tb/sim_serial_csr_apb.sv
`timescale 1ns/100ps
module sim_serial_csr_apb;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata;
  logic          pready;
  logic          core_busy, core_rx_ready, core_error;
  logic [BW-1:0] core_rx_byte;
  logic          tx_start;
  logic [BW-1:0] tx_byte;
  logic          rx_pop;
  logic [DW-1:0] ctrl_out, baud_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  serial_csr_apb #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) u0 (.*);

  // Vector: {is_read, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hA5A5_0003, 32'h0},          // R2 config write
    {1'b1, 8'h00, 32'h0,         32'hA5A5_0003},  // R2
    {1'b0, 8'h08, 32'h0000_01B2, 32'h0},          // R2 divisor write
    {1'b1, 8'h08, 32'h0,         32'h0000_01B2},  // R2
    {1'b0, 8'h04, 32'hFFFF_FFFF, 32'h0},          // R5 write to flags
    {1'b1, 8'h04, 32'h0,         32'h0000_0005},  // R5 R7 flags still core-driven
    {1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0},          // R5 write to receive port
    {1'b1, 8'h10, 32'h0,         32'h0000_005A},  // R8 receive byte
    {1'b1, 8'h00, 32'h0,         32'hA5A5_0003},  // R5 config untouched
    {1'b0, 8'h14, 32'h0000_1234, 32'h0},          // R4 unmapped write
    {1'b1, 8'h14, 32'h0,         32'h0},          // R4 unmapped read
    {1'b0, 8'h01, 32'hDEAD_BEEF, 32'h0},          // R4 misaligned write
    {1'b1, 8'h01, 32'h0,         32'h0},          // R4
    {1'b1, 8'h00, 32'h0,         32'hA5A5_0003},  // R4 config untouched
    {1'b1, 8'h0C, 32'h0,         32'h0},          // R6 send port reads zero
    {1'b1, 8'h08, 32'h0,         32'h0000_01B2}   // R4 divisor untouched
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup_ph(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
  endtask

  task automatic access_ph();
    @(negedge clk);
    penable = 1'b1;
    #0.5;
  endtask

  task automatic end_ph();
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    setup_ph(a, 1'b1, d);
    access_ph();
    end_ph();
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    setup_ph(a, 1'b0, '0);
    access_ph();
    d = prdata;
    end_ph();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    core_busy = 1'b1; core_rx_ready = 1'b0; core_error = 1'b1; core_rx_byte = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 R11 reset state
    chk("R1 tx_start", {31'b0, tx_start}, 32'h0);
    chk("R1 rx_pop",   {31'b0, rx_pop}, 32'h0);
    chk("R1 tx_byte",  {24'b0, tx_byte}, 32'h0);
    chk("R11 pready",  {31'b0, pready}, 32'h1);
    bus_read(8'h00, rd); chk("R1 config", rd, 32'h0);
    bus_read(8'h08, rd); chk("R1 divisor", rd, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) begin
        bus_read(VEC[i][71:64], rd);
        chk($sformatf("vector %0d", i), rd, VEC[i][31:0]);
      end else begin
        bus_write(VEC[i][71:64], VEC[i][63:32]);
      end
    end

    // R12 mirror outputs
    chk("R12 ctrl_out", ctrl_out, 32'hA5A5_0003);
    chk("R12 baud_out", baud_out, 32'h0000_01B2);

    // R3 SETUP-only write and select-less enable change nothing
    setup_ph(8'h00, 1'b1, 32'h1111_1111);
    end_ph();
    @(negedge clk); psel = 0; penable = 1; pwrite = 1; paddr = 8'h08; pwdata = 32'h2222_2222;
    @(negedge clk); penable = 0;
    chk("R3 config after setup", ctrl_out, 32'hA5A5_0003);
    chk("R3 divisor after stray enable", baud_out, 32'h0000_01B2);
    setup_ph(8'h0C, 1'b1, 32'h0000_0077);
    @(negedge clk); psel = 0; pwrite = 0;
    chk("R3 no tx_start from setup", {31'b0, tx_start}, 32'h0);
    setup_ph(8'h10, 1'b0, '0);
    @(negedge clk); psel = 0;
    chk("R10 no rx_pop from setup", {31'b0, rx_pop}, 32'h0);

    // R9 send strobe, one cycle, right byte
    setup_ph(8'h0C, 1'b1, 32'h1234_56C3);
    access_ph();
    chk("R9 no pulse during access", {31'b0, tx_start}, 32'h0);
    end_ph();
    chk("R9 pulse after access", {31'b0, tx_start}, 32'h1);
    chk("R9 byte", {24'b0, tx_byte}, 32'h0000_00C3);
    @(negedge clk);
    chk("R9 pulse ends", {31'b0, tx_start}, 32'h0);
    chk("R9 byte held", {24'b0, tx_byte}, 32'h0000_00C3);
    bus_write(8'h0C, 32'h0000_003C);
    chk("R9 second pulse", {31'b0, tx_start}, 32'h1);
    chk("R9 second byte", {24'b0, tx_byte}, 32'h0000_003C);

    // R5 writes to read-only ports raise no strobe
    bus_write(8'h10, 32'h0000_00FF);
    chk("R5 no tx_start", {31'b0, tx_start}, 32'h0);
    chk("R5 no rx_pop",   {31'b0, rx_pop}, 32'h0);

    // R10 receive pop
    core_rx_byte = 8'h81;
    bus_read(8'h10, rd);
    chk("R8 receive byte", rd, 32'h0000_0081);
    chk("R10 pop after access", {31'b0, rx_pop}, 32'h1);
    @(negedge clk);
    chk("R10 pop ends", {31'b0, rx_pop}, 32'h0);

    // R7 flag bits in every combination
    for (int k = 0; k < 8; k++) begin
      core_busy = k[0]; core_rx_ready = k[1]; core_error = k[2];
      bus_read(8'h04, rd);
      chk("R7 flags", rd, 32'(k));
    end

    // R1 reset after use
    bus_write(8'h00, 32'h0000_00F0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 config after reset", ctrl_out, 32'h0);
    chk("R1 divisor after reset", baud_out, 32'h0);
    chk("R1 tx_byte after reset", {24'b0, tx_byte}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule